// File: doc/BRIEF.md
# First/Next Memory Error Logger

The logger sits beside a DRAM controller's ECC path. It records error events without decoding ECC itself. Each event pulse says whether the error was correctable or uncorrectable. It also carries the 4 KiB page number of the failing physical address and a 16-bit syndrome. Two 8-bit status registers are kept, a first-error register and a next-error register. In each one, bit 0 marks a correctable error and bit 1 marks an uncorrectable error.

The first error of each type freezes that type's logs. For a correctable error these are the address log and the syndrome log; for an uncorrectable error it is the address log alone. A repeat of that type while the first-error bit is still set only raises the next-error bit. Software can then tell that later errors were lost. Software clears a status bit by writing 1 to it, and clears both registers once at start-up.

An interrupt request stays high while any of the four status bits is set. A channel indication is decoded from the logged correctable syndrome.

Top module: `mem_err_logger`

## Requirements
- R1: After reset, both status registers, all three logs, `err_irq` and `ce_channel` are zero.
- R2: A correctable event (`evt_uncorr`=0) while first-status bit 0 is clear sets first-status bit 0. In the same clock it loads the correctable address log and `ce_syndrome_log` from the event.
- R3: An uncorrectable event (`evt_uncorr`=1) while first-status bit 1 is clear sets first-status bit 1 and loads `ue_addr_log`. The correctable logs are left unchanged.
- R4: An event whose first-status bit is already set sets the matching next-status bit and leaves every log unchanged.
- R5: A write with `wr_en`=1 clears each bit of the selected register whose `wr_mask` bit is 1. `wr_sel`=0 selects first status and `wr_sel`=1 selects next status; `wr_mask[0]` addresses bit 0 and `wr_mask[1]` addresses bit 1. Mask bits of 0 have no effect, and status bits 7:2 always read 0.
- R6: When a clear and a new event hit the same status bit in the same cycle, the bit stays set.
- R7: An event whose first-status bit is clear sets that bit and reloads the logs even when its next-status bit is set. The next-status bit stays set.
- R8: `err_irq` is high exactly while at least one of the four status bits is set.
- R9: `ce_channel` is decoded from `ce_syndrome_log`:
  - 0 when syndrome bits 15:8 are zero;
  - otherwise 1 when bits 7:0 are zero;
  - otherwise 0 when bits 15:12 or bits 11:8 are zero;
  - otherwise 1.
- R10: In both address logs, bits 27:6 hold the event page number (physical address bits 33:12), and bits 31:28 and 5:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event pulse, one cycle per event |
| evt_uncorr | input | 1 | 0 = correctable, 1 = uncorrectable |
| evt_page | input | 22 | Physical address bits 33:12 of the failing access |
| evt_syndrome | input | 16 | ECC syndrome of the event |
| wr_en | input | 1 | Status clear write strobe |
| wr_sel | input | 1 | 0 = first status, 1 = next status |
| wr_mask | input | 2 | Write-1-to-clear mask for status bits 1:0 |
| first_status | output | 8 | First-error status |
| next_status | output | 8 | Next-error status |
| ce_addr_log | output | 32 | Correctable error address log |
| ue_addr_log | output | 32 | Uncorrectable error address log |
| ce_syndrome_log | output | 16 | Correctable error syndrome log |
| err_irq | output | 1 | Interrupt request |
| ce_channel | output | 1 | Channel decoded from the logged syndrome |

## Verification
The assertions assume that an event lasts exactly one cycle and carries a single type. They also assume that a clear write only ever touches bits 1:0, because that is all the port can express. The stimulus drives each event or write for one cycle only and then returns the inputs to idle. Events and clears are placed on the same cycle only in the collision cases. Those cases probe both registers, so every event-wins path is checked against an expected value that the bench computes on its own.

// File: rtl/mel_pkg.sv
package mel_pkg;
    localparam int PA_W       = 34;
    localparam int PAGE_SHIFT = 12;
    localparam int PAGE_W     = PA_W - PAGE_SHIFT;
    localparam int LOG_W      = 32;
    localparam int LOG_LSB    = 6;
    localparam int SYN_W      = 16;
    localparam int STAT_W     = 8;
    localparam int N_KIND     = 2;

    typedef enum logic {
        KIND_CORR   = 1'b0,
        KIND_UNCORR = 1'b1
    } err_kind_e;

    typedef struct packed {
        logic              valid;
        err_kind_e         kind;
        logic [PAGE_W-1:0] page;
        logic [SYN_W-1:0]  syn;
    } err_evt_t;

    function automatic logic [LOG_W-1:0] place_page(input logic [PAGE_W-1:0] pg);
        logic [LOG_W-1:0] r;
        r = '0;
        r[LOG_LSB +: PAGE_W] = pg;
        return r;
    endfunction

    function automatic logic syn_to_channel(input logic [SYN_W-1:0] s);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = s[15:8];
        lo = s[7:0];
        if (hi == 8'h00)                          return 1'b0;
        else if (lo == 8'h00)                     return 1'b1;
        else if (hi[7:4] == 4'h0 || hi[3:0] == 4'h0) return 1'b0;
        else                                      return 1'b1;
    endfunction
endpackage

// File: rtl/mel_status_cell.sv
module mel_status_cell (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr_first,
    input  logic clr_next,
    output logic first_q,
    output logic next_q,
    output logic load
);
    assign load = hit && !first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            next_q  <= 1'b0;
        end else begin
            // a new event always wins over a same-cycle clear
            if (hit)            first_q <= 1'b1;
            else if (clr_first) first_q <= 1'b0;

            if (hit && first_q) next_q <= 1'b1;
            else if (clr_next)  next_q <= 1'b0;
        end
    end
endmodule

// File: rtl/mel_addr_log.sv
module mel_addr_log
    import mel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [PAGE_W-1:0] page,
    output logic [LOG_W-1:0]  log_q
);
    always_ff @(posedge clk) begin
        if (rst)       log_q <= '0;
        else if (load) log_q <= place_page(page);
    end
endmodule

// File: rtl/mel_chan_decode.sv
module mel_chan_decode
    import mel_pkg::*;
(
    input  logic [SYN_W-1:0] syn,
    output logic             chan
);
    always_comb chan = syn_to_channel(syn);
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
    import mel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic              evt_uncorr,
    input  logic [PAGE_W-1:0] evt_page,
    input  logic [SYN_W-1:0]  evt_syndrome,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [N_KIND-1:0] wr_mask,
    output logic [STAT_W-1:0] first_status,
    output logic [STAT_W-1:0] next_status,
    output logic [LOG_W-1:0]  ce_addr_log,
    output logic [LOG_W-1:0]  ue_addr_log,
    output logic [SYN_W-1:0]  ce_syndrome_log,
    output logic              err_irq,
    output logic              ce_channel
);
    err_evt_t          evt;
    logic [N_KIND-1:0] hit;
    logic [N_KIND-1:0] load;
    logic [N_KIND-1:0] first_q;
    logic [N_KIND-1:0] next_q;
    logic [N_KIND-1:0] clr_first;
    logic [N_KIND-1:0] clr_next;

    always_comb begin
        evt.valid = evt_valid;
        evt.kind  = err_kind_e'(evt_uncorr);
        evt.page  = evt_page;
        evt.syn   = evt_syndrome;
    end

    assign clr_first = (wr_en && !wr_sel) ? wr_mask : '0;
    assign clr_next  = (wr_en &&  wr_sel) ? wr_mask : '0;

    for (genvar k = 0; k < N_KIND; k++) begin : g_kind
        assign hit[k] = evt.valid && (evt.kind == err_kind_e'(k));

        mel_status_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .hit       (hit[k]),
            .clr_first (clr_first[k]),
            .clr_next  (clr_next[k]),
            .first_q   (first_q[k]),
            .next_q    (next_q[k]),
            .load      (load[k])
        );
    end

    mel_addr_log u_ce_log (
        .clk   (clk),
        .rst   (rst),
        .load  (load[KIND_CORR]),
        .page  (evt.page),
        .log_q (ce_addr_log)
    );

    mel_addr_log u_ue_log (
        .clk   (clk),
        .rst   (rst),
        .load  (load[KIND_UNCORR]),
        .page  (evt.page),
        .log_q (ue_addr_log)
    );

    always_ff @(posedge clk) begin
        if (rst)                   ce_syndrome_log <= '0;
        else if (load[KIND_CORR])  ce_syndrome_log <= evt.syn;
    end

    mel_chan_decode u_chan (
        .syn  (ce_syndrome_log),
        .chan (ce_channel)
    );

    assign first_status = {{(STAT_W-N_KIND){1'b0}}, first_q};
    assign next_status  = {{(STAT_W-N_KIND){1'b0}}, next_q};
    assign err_irq      = |{first_q, next_q};
endmodule

// File: rtl/mel_checker.sv
module mel_checker (
    input logic        clk,
    input logic        rst,
    input logic        evt_valid,
    input logic        evt_uncorr,
    input logic        wr_en,
    input logic [7:0]  first_status,
    input logic [7:0]  next_status,
    input logic [31:0] ce_addr_log,
    input logic [31:0] ue_addr_log,
    input logic [15:0] ce_syndrome_log,
    input logic        err_irq
);
    a_r2_ce_sets_first: assert property (@(posedge clk) disable iff (rst)
        evt_valid && !evt_uncorr |=> first_status[0]);

    a_r3_ue_sets_first: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_uncorr |=> first_status[1]);

    a_r4_ce_log_frozen: assert property (@(posedge clk) disable iff (rst)
        evt_valid && !evt_uncorr && first_status[0]
        |=> $stable(ce_addr_log) && $stable(ce_syndrome_log) && next_status[0]);

    a_r4_ue_log_frozen: assert property (@(posedge clk) disable iff (rst)
        evt_valid && evt_uncorr && first_status[1]
        |=> $stable(ue_addr_log) && next_status[1]);

    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        first_status[7:2] == 6'd0 && next_status[7:2] == 6'd0);

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        err_irq && !wr_en |=> err_irq);

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(err_irq) |-> $past(evt_valid));

    a_r10_log_format: assert property (@(posedge clk) disable iff (rst)
        ce_addr_log[31:28] == 4'd0 && ce_addr_log[5:0] == 6'd0 &&
        ue_addr_log[31:28] == 4'd0 && ue_addr_log[5:0] == 6'd0);
endmodule

bind mem_err_logger mel_checker u_chk (.*);

// File: tb/tb_mem_err_logger.sv
module tb_mem_err_logger;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic        evt_uncorr = 1'b0;
    logic [21:0] evt_page = '0;
    logic [15:0] evt_syndrome = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [1:0]  wr_mask = '0;
    logic [7:0]  first_status, next_status;
    logic [31:0] ce_addr_log, ue_addr_log;
    logic [15:0] ce_syndrome_log;
    logic        err_irq, ce_channel;

    always #10 clk = ~clk;

    mem_err_logger dut (.*);

    typedef struct packed {
        logic [7:0]  fs;
        logic [7:0]  ns;
        logic [31:0] cea;
        logic [31:0] uea;
        logic [15:0] syn;
        logic        irq;
        logic        ch;
    } snap_t;

    snap_t exp_q[$];
    string tag_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench-side model state
    logic [1:0]  mf = '0, mn = '0;
    logic [31:0] m_cea = '0, m_uea = '0;
    logic [15:0] m_syn = '0;

    function automatic logic exp_chan(input logic [15:0] s);
        if (s[15:8] == 0) return 1'b0;
        if (s[7:0] == 0) return 1'b1;
        if (s[15:12] == 0 || s[11:8] == 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [21:0] p);
        return {4'h0, p, 6'h00};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: drives one cycle, updates the model, pushes the expectation
    task automatic op(input bit v, input bit ue, input logic [21:0] pg,
                      input logic [15:0] sy, input bit we, input bit sel,
                      input logic [1:0] msk, input string tag);
        logic [1:0] old_f;
        snap_t s;
        @(negedge clk);
        evt_valid = v; evt_uncorr = ue; evt_page = pg; evt_syndrome = sy;
        wr_en = we; wr_sel = sel; wr_mask = msk;
        old_f = mf;
        for (int k = 0; k < 2; k++) begin
            bit h;
            h = v && (ue == k[0]);
            if (h) begin
                if (!old_f[k]) begin
                    mf[k] = 1'b1;
                    if (k == 0) begin m_cea = exp_addr(pg); m_syn = sy; end
                    else m_uea = exp_addr(pg);
                end else begin
                    mn[k] = 1'b1;
                end
            end
            if (we && !sel && msk[k] && !h) mf[k] = 1'b0;
            if (we && sel && msk[k] && !(h && old_f[k])) mn[k] = 1'b0;
        end
        @(posedge clk);
        s.fs = {6'd0, mf};
        s.ns = {6'd0, mn};
        s.cea = m_cea;
        s.uea = m_uea;
        s.syn = m_syn;
        s.irq = |{mf, mn};
        s.ch = exp_chan(m_syn);
        exp_q.push_back(s);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        op(0, 0, '0, '0, 0, 0, 2'b00, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            snap_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, "first_status", {24'd0, first_status}, {24'd0, e.fs});
            check(t, "next_status", {24'd0, next_status}, {24'd0, e.ns});
            check(t, "ce_addr_log", ce_addr_log, e.cea);
            check(t, "ue_addr_log", ue_addr_log, e.uea);
            check(t, "ce_syndrome_log", {16'd0, ce_syndrome_log}, {16'd0, e.syn});
            check(t, "err_irq", {31'd0, err_irq}, {31'd0, e.irq});
            check(t, "ce_channel", {31'd0, ce_channel}, {31'd0, e.ch});
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle("R1 reset state");
        // R2 R10 R9: first correctable error, channel 0 via zero upper byte
        op(1, 0, 22'h2ABCD5, 16'h00AB, 0, 0, 2'b00, "R2 R10 R9");
        // R3: first uncorrectable error
        op(1, 1, 22'h015A5A, 16'hFFFF, 0, 0, 2'b00, "R3 R10");
        // R4: repeats of each type go to next status only
        op(1, 0, 22'h3FFFFF, 16'hAB00, 0, 0, 2'b00, "R4 ce repeat");
        op(1, 1, 22'h000001, 16'h1234, 0, 0, 2'b00, "R4 ue repeat");
        // R5: zero mask has no effect, then clear first bit 0
        op(0, 0, '0, '0, 1, 0, 2'b00, "R5 zero mask");
        op(0, 0, '0, '0, 1, 0, 2'b01, "R5 clear first ce");
        // R7: first clear, next set -> reload logs, channel 1
        op(1, 0, 22'h123456 & 22'h3FFFFF, 16'hAB00, 0, 0, 2'b00, "R7 R9");
        // R6: collisions on first and next bits
        op(1, 0, 22'h0F0F0F, 16'h5555, 1, 0, 2'b01, "R6 first collision");
        op(1, 1, 22'h0F0F0F, 16'h5555, 1, 1, 2'b10, "R6 next collision");
        // R5 R8: clear everything, interrupt drops
        op(0, 0, '0, '0, 1, 1, 2'b11, "R5 clear next");
        op(0, 0, '0, '0, 1, 0, 2'b11, "R5 R8 clear first");
        idle("R8 idle");
        // R9: channel decode cases
        op(1, 0, 22'h000100, 16'h0A5B, 0, 0, 2'b00, "R9 hi nibble zero");
        op(0, 0, '0, '0, 1, 0, 2'b01, "R5 clear");
        op(1, 0, 22'h000200, 16'hA05B, 0, 0, 2'b00, "R9 lo nibble zero");
        op(0, 0, '0, '0, 1, 0, 2'b01, "R5 clear");
        op(1, 0, 22'h000300, 16'hAB5C, 0, 0, 2'b00, "R9 all nonzero");
        op(0, 0, '0, '0, 1, 0, 2'b01, "R5 clear");
        op(1, 0, 22'h000400, 16'h0000, 0, 0, 2'b00, "R9 zero syndrome");
        // R8: next-only state keeps irq high
        op(1, 0, 22'h000500, 16'h1111, 0, 0, 2'b00, "R4 R8");
        op(0, 0, '0, '0, 1, 0, 2'b01, "R8 next only");
        idle("R8 hold");
        repeat (3) @(negedge clk);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule